// File: doc/BRIEF.md
# Replication-Aware Spill Replacement Controller

This block chooses the victim way and decides what happens to the evicted block, for one private second-level cache in a multicore where the private caches lend capacity to each other. It keeps the following state for every way of every set:

- a recency rank,
- a valid bit,
- a singlet bit, which is set when no other cache on the chip holds a copy,
- a spilled bit, which marks a block that arrived from a peer and has not been reused since.

The data arrays, the network and the coherence protocol are outside the block. They feed it the singlet information, the hits, the local fills and the blocks spilled in from peers. In return they receive the victim way and an action for each install, and a spill request for a chosen peer.

A replicated block can be dropped at no cost to the chip, so it is taken before a singlet. A singlet that must leave is sent once to a randomly chosen peer. There it is installed as most recent. If that block ages out again without being touched, it leaves the chip.

Two 8-bit probabilities throttle this cooperation. Each is compared against a free-running LFSR. Setting both to 0 gives a plain private LRU cache.

Top module: `spill_repl_ctrl`

## Requirements
- R1: After reset every way is invalid and the ranks put way 0 as most recent up to way 3 as least recent. `fill_ready_o` and `spin_ready_o` are 1, and `evict_valid_o` and `spill_valid_o` are 0.
- R2: If the set has an invalid way, the lowest-numbered invalid way is used and the action is FREE (0).
- R3: With a cooperation probability of 255 and no invalid way, the victim is the least recently used block whose singlet bit is 0. Such a victim has action SILENT (1).
- R4: With a cooperation probability of 0, or when every block in the set is a singlet, the victim is the least recently used way.
- R5: Every install and every hit on a valid way makes that way most recent. Ways that were more recent move one place older, and the others keep their order.
- R6: A singlet victim whose spilled bit is 0, evicted with a spill probability of 255, gets action SPILL (2). `spill_valid_o` rises in the same cycle as `evict_valid_o`, with the victim's set and a target core other than `CORE_ID` and below `NUM_CORES`. The request is held unchanged until `spill_ready_i` is 1.
- R7: A singlet victim evicted with a spill probability of 0 gets action DROP (3), and no spill is issued.
- R8: A block taken in on the spill-in channel is installed as most recent, with its singlet and spilled bits set. If it is chosen as a victim while its spilled bit is still set, the action is DROP (3), whatever the spill probability.
- R9: A hit clears the spilled bit of the way it hits. A block spilled in and then reused is spilled again when it is evicted later.
- R10: A singlet update writes the given value into the singlet bit of one way, and this changes which way is chosen as the next victim.
- R11: An accepted request drops `fill_ready_o` in the next cycle. `evict_valid_o` is a one-cycle pulse in the cycle after that, carrying the set, the way and the action.
- R12: When a local fill and a spill-in are both valid while the block is idle, the local fill is taken and `spin_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coop_prob_i | input | 8 | Chance of applying replication-aware selection (0 never, 255 always, otherwise value/256) |
| spill_prob_i | input | 8 | Chance of spilling an eligible singlet (same encoding) |
| fill_valid_i | input | 1 | Local fill request |
| fill_ready_o | output | 1 | Block idle, local fill accepted |
| fill_set_i | input | SW | Set of the local fill |
| fill_singlet_i | input | 1 | Singlet bit of the incoming local block |
| spin_valid_i | input | 1 | Block spilled in from a peer |
| spin_ready_o | output | 1 | Spill-in accepted |
| spin_set_i | input | SW | Set of the spilled-in block |
| hit_valid_i | input | 1 | Reuse of a resident block |
| hit_set_i | input | SW | Set of the hit |
| hit_way_i | input | RW | Way of the hit |
| sing_valid_i | input | 1 | Singlet bit update |
| sing_set_i | input | SW | Set of the update |
| sing_way_i | input | RW | Way of the update |
| sing_val_i | input | 1 | New singlet value |
| evict_valid_o | output | 1 | Victim decision pulse |
| evict_set_o | output | SW | Set of the install |
| evict_way_o | output | RW | Victim way, which receives the new block |
| evict_action_o | output | 2 | 0 FREE, 1 SILENT, 2 SPILL, 3 DROP |
| spill_valid_o | output | 1 | Spill request to a peer |
| spill_ready_i | input | 1 | Spill request taken |
| spill_set_o | output | SW | Set of the spilled block |
| spill_target_o | output | CW | Peer core receiving the spill |

## Verification
The bench sweeps all four combinations of the two probabilities at their extremes over every set. The sweep interleaves local fills, spill-ins, hits and singlet updates in arithmetic patterns, and compares each decision with a model of the requirements.

The sweep is run under several probability settings, and each one exposes a different fault:
- Cooperation off exposes a wrong recency order.
- Cooperation on exposes a replicated block passed over for a singlet.
- Spill off exposes spills that should not happen.
- Spill on exposes a block spilled a second time, or a spill with a bad target or one that is not held.

Directed sequences then cover reuse after a spill-in, a singlet update that makes a most-recent block the victim, and a fill racing a spill-in.

// File: rtl/spill_repl_pkg.sv
package spill_repl_pkg;
  typedef enum logic [1:0] {
    ACT_FREE   = 2'd0,
    ACT_SILENT = 2'd1,
    ACT_SPILL  = 2'd2,
    ACT_DROP   = 2'd3
  } evict_act_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PICK  = 2'd1,
    ST_SPILL = 2'd2
  } ctrl_state_e;

  // 0 never, 255 always, otherwise prob/256
  function automatic logic prob_hit(logic [7:0] rnd, logic [7:0] prob);
    return (prob == 8'hFF) || (rnd < prob);
  endfunction
endpackage

// File: rtl/spill_repl_lfsr.sv
module spill_repl_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else if (s_q[0]) s_q <= (s_q >> 1) ^ TAPS;
    else s_q <= s_q >> 1;
  end

  assign rnd_o = s_q;

  AST_LFSR_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni) s_q != '0); // R6
endmodule

// File: rtl/spill_repl_pick.sv
module spill_repl_pick
  import spill_repl_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int RW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]         valid_i,
  input  logic [WAYS-1:0]         singlet_i,
  input  logic [WAYS-1:0]         spilled_i,
  input  logic [WAYS-1:0][RW-1:0] rank_i,
  input  logic                    coop_en_i,
  input  logic                    spill_en_i,
  output logic [RW-1:0]           way_o,
  output evict_act_e              act_o
);
  logic          free_found, rep_found;
  logic [RW-1:0] free_way, rep_way, rep_rank, lru_way;

  always_comb begin
    free_found = 1'b0;
    free_way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) begin
        free_found = 1'b1;
        free_way   = RW'(w);
      end
    end
    rep_found = 1'b0;
    rep_way   = '0;
    rep_rank  = '0;
    lru_way   = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (valid_i[w] && !singlet_i[w] && (!rep_found || rank_i[w] > rep_rank)) begin
        rep_found = 1'b1;
        rep_way   = RW'(w);
        rep_rank  = rank_i[w];
      end
      if (rank_i[w] == RW'(WAYS - 1)) lru_way = RW'(w);
    end
    if (free_found) way_o = free_way;
    else if (coop_en_i && rep_found) way_o = rep_way;
    else way_o = lru_way;

    if (free_found) act_o = ACT_FREE;
    else if (!singlet_i[way_o]) act_o = ACT_SILENT;
    else if (spilled_i[way_o]) act_o = ACT_DROP;   // second chance already used
    else if (spill_en_i) act_o = ACT_SPILL;
    else act_o = ACT_DROP;
  end
endmodule

// File: rtl/spill_repl_store.sv
module spill_repl_store #(
  parameter int SETS = 64,
  parameter int WAYS = 4,
  localparam int SW  = $clog2(SETS),
  localparam int RW  = $clog2(WAYS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [SW-1:0]           rd_set_i,
  output logic [WAYS-1:0]         valid_o,
  output logic [WAYS-1:0]         singlet_o,
  output logic [WAYS-1:0]         spilled_o,
  output logic [WAYS-1:0][RW-1:0] rank_o,
  input  logic                    wr_en_i,
  input  logic [SW-1:0]           wr_set_i,
  input  logic [RW-1:0]           wr_way_i,
  input  logic                    wr_singlet_i,
  input  logic                    wr_spilled_i,
  input  logic                    hit_en_i,
  input  logic [SW-1:0]           hit_set_i,
  input  logic [RW-1:0]           hit_way_i,
  input  logic                    sing_en_i,
  input  logic [SW-1:0]           sing_set_i,
  input  logic [RW-1:0]           sing_way_i,
  input  logic                    sing_val_i
);
  typedef logic [WAYS-1:0][RW-1:0] rank_vec_t;

  logic [WAYS-1:0] valid_q   [SETS];
  logic [WAYS-1:0] singlet_q [SETS];
  logic [WAYS-1:0] spilled_q [SETS];
  rank_vec_t       rank_q    [SETS];

  function automatic rank_vec_t promote(rank_vec_t r, logic [RW-1:0] w);
    rank_vec_t n = r;
    for (int j = 0; j < WAYS; j++)
      if (r[j] < r[w]) n[j] = r[j] + 1'b1;
    n[w] = '0;
    return n;
  endfunction

  logic hit_ok, sing_ok;
  // the install owns its set for the cycle
  assign hit_ok  = hit_en_i && !(wr_en_i && wr_set_i == hit_set_i);
  assign sing_ok = sing_en_i && !(wr_en_i && wr_set_i == sing_set_i && wr_way_i == sing_way_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s]   <= '0;
        singlet_q[s] <= '0;
        spilled_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= RW'(w);
      end
    end else begin
      if (wr_en_i) begin
        rank_q[wr_set_i]              <= promote(rank_q[wr_set_i], wr_way_i);
        valid_q[wr_set_i][wr_way_i]   <= 1'b1;
        singlet_q[wr_set_i][wr_way_i] <= wr_singlet_i;
        spilled_q[wr_set_i][wr_way_i] <= wr_spilled_i;
      end
      if (hit_ok) begin
        if (valid_q[hit_set_i][hit_way_i])
          rank_q[hit_set_i] <= promote(rank_q[hit_set_i], hit_way_i);
        spilled_q[hit_set_i][hit_way_i] <= 1'b0;
      end
      if (sing_ok) singlet_q[sing_set_i][sing_way_i] <= sing_val_i;
    end
  end

  assign valid_o   = valid_q[rd_set_i];
  assign singlet_o = singlet_q[rd_set_i];
  assign spilled_o = spilled_q[rd_set_i];
  assign rank_o    = rank_q[rd_set_i];

  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[rank_o[w]] = 1'b1;
  end

  AST_RANK_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni) &seen); // R5
endmodule

// File: rtl/spill_repl_ctrl.sv
module spill_repl_ctrl
  import spill_repl_pkg::*;
#(
  parameter int NUM_SETS  = 64,
  parameter int NUM_WAYS  = 4,
  parameter int NUM_CORES = 8,
  parameter int CORE_ID   = 0,
  parameter int LFSR_W    = 16,
  localparam int SW       = $clog2(NUM_SETS),
  localparam int RW       = $clog2(NUM_WAYS),
  localparam int CW       = $clog2(NUM_CORES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    coop_prob_i,
  input  logic [7:0]    spill_prob_i,
  input  logic          fill_valid_i,
  output logic          fill_ready_o,
  input  logic [SW-1:0] fill_set_i,
  input  logic          fill_singlet_i,
  input  logic          spin_valid_i,
  output logic          spin_ready_o,
  input  logic [SW-1:0] spin_set_i,
  input  logic          hit_valid_i,
  input  logic [SW-1:0] hit_set_i,
  input  logic [RW-1:0] hit_way_i,
  input  logic          sing_valid_i,
  input  logic [SW-1:0] sing_set_i,
  input  logic [RW-1:0] sing_way_i,
  input  logic          sing_val_i,
  output logic          evict_valid_o,
  output logic [SW-1:0] evict_set_o,
  output logic [RW-1:0] evict_way_o,
  output logic [1:0]    evict_action_o,
  output logic          spill_valid_o,
  input  logic          spill_ready_i,
  output logic [SW-1:0] spill_set_o,
  output logic [CW-1:0] spill_target_o
);
  localparam int PEERS = NUM_CORES - 1;

  ctrl_state_e   state_q;
  logic [SW-1:0] req_set_q;
  logic          req_singlet_q, req_spilled_q;
  logic [LFSR_W-1:0] rnd;

  logic [NUM_WAYS-1:0]         st_valid, st_singlet, st_spilled;
  logic [NUM_WAYS-1:0][RW-1:0] st_rank;
  logic [RW-1:0]               pick_way;
  evict_act_e                  pick_act;
  logic                        coop_en, spill_en, in_pick;
  logic [31:0]                 peer_idx;
  logic [CW-1:0]               peer_tgt;

  spill_repl_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .rnd_o(rnd)
  );

  assign in_pick  = (state_q == ST_PICK);
  assign coop_en  = prob_hit(rnd[7:0], coop_prob_i);
  assign spill_en = prob_hit(rnd[15:8], spill_prob_i);

  // uniform-ish pick among peers, skipping the local core
  always_comb begin
    peer_idx = 32'(rnd[11:4]) % 32'(PEERS);
    if (peer_idx >= 32'(CORE_ID)) peer_idx = peer_idx + 32'd1;
    peer_tgt = CW'(peer_idx);
  end

  spill_repl_store #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd_set_i(req_set_q),
    .valid_o(st_valid), .singlet_o(st_singlet), .spilled_o(st_spilled), .rank_o(st_rank),
    .wr_en_i(in_pick), .wr_set_i(req_set_q), .wr_way_i(pick_way),
    .wr_singlet_i(req_singlet_q), .wr_spilled_i(req_spilled_q),
    .hit_en_i(hit_valid_i), .hit_set_i(hit_set_i), .hit_way_i(hit_way_i),
    .sing_en_i(sing_valid_i), .sing_set_i(sing_set_i), .sing_way_i(sing_way_i),
    .sing_val_i(sing_val_i)
  );

  spill_repl_pick #(.WAYS(NUM_WAYS)) u_pick (
    .valid_i(st_valid), .singlet_i(st_singlet), .spilled_i(st_spilled), .rank_i(st_rank),
    .coop_en_i(coop_en), .spill_en_i(spill_en),
    .way_o(pick_way), .act_o(pick_act)
  );

  assign fill_ready_o  = (state_q == ST_IDLE);
  assign spin_ready_o  = (state_q == ST_IDLE) && !fill_valid_i;
  assign spill_valid_o = (state_q == ST_SPILL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      req_set_q      <= '0;
      req_singlet_q  <= 1'b0;
      req_spilled_q  <= 1'b0;
      evict_valid_o  <= 1'b0;
      evict_set_o    <= '0;
      evict_way_o    <= '0;
      evict_action_o <= '0;
      spill_set_o    <= '0;
      spill_target_o <= '0;
    end else begin
      evict_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fill_valid_i) begin
            req_set_q     <= fill_set_i;
            req_singlet_q <= fill_singlet_i;
            req_spilled_q <= 1'b0;
            state_q       <= ST_PICK;
          end else if (spin_valid_i) begin
            req_set_q     <= spin_set_i;
            req_singlet_q <= 1'b1;
            req_spilled_q <= 1'b1;
            state_q       <= ST_PICK;
          end
        end
        ST_PICK: begin
          evict_valid_o  <= 1'b1;
          evict_set_o    <= req_set_q;
          evict_way_o    <= pick_way;
          evict_action_o <= pick_act;
          if (pick_act == ACT_SPILL) begin
            spill_set_o    <= req_set_q;
            spill_target_o <= peer_tgt;
            state_q        <= ST_SPILL;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: if (spill_ready_i) state_q <= ST_IDLE;
      endcase
    end
  end

  AST_REPL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pick && coop_en && (&st_valid) && |(st_valid & ~st_singlet)) |-> !st_singlet[pick_way]); // R3
  AST_ONE_CHANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pick && pick_act == ACT_SPILL) |-> !st_spilled[pick_way]); // R8
  AST_SPILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_valid_o && !spill_ready_i) |=> (spill_valid_o && $stable(spill_target_o) && $stable(spill_set_o))); // R6
  AST_SPILL_PEER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_valid_o |-> (spill_target_o != CW'(CORE_ID) && int'(spill_target_o) < NUM_CORES)); // R6
  AST_SPILL_WITH_EVICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_o && evict_action_o == 2'd2) |-> spill_valid_o); // R6
  AST_EVICT_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && fill_ready_o) |=> (!fill_ready_o && !evict_valid_o) ##1 evict_valid_o); // R11
endmodule

// File: tb/spill_repl_ctrl_test.sv
`timescale 1ns/1ps
module spill_repl_ctrl_test;
  localparam int S = 4, W = 4, C = 4, ME = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [7:0] coop_prob, spill_prob;
  logic       fill_valid, fill_ready, fill_singlet;
  logic [1:0] fill_set;
  logic       spin_valid, spin_ready;
  logic [1:0] spin_set;
  logic       hit_valid;
  logic [1:0] hit_set, hit_way;
  logic       sing_valid, sing_val;
  logic [1:0] sing_set, sing_way;
  logic       evict_valid;
  logic [1:0] evict_set, evict_way, evict_action;
  logic       spill_valid, spill_ready;
  logic [1:0] spill_set, spill_target;

  spill_repl_ctrl #(.NUM_SETS(S), .NUM_WAYS(W), .NUM_CORES(C), .CORE_ID(ME)) uut (
    .clk_i(clk), .rst_ni(rst_n), .coop_prob_i(coop_prob), .spill_prob_i(spill_prob),
    .fill_valid_i(fill_valid), .fill_ready_o(fill_ready), .fill_set_i(fill_set),
    .fill_singlet_i(fill_singlet), .spin_valid_i(spin_valid), .spin_ready_o(spin_ready),
    .spin_set_i(spin_set), .hit_valid_i(hit_valid), .hit_set_i(hit_set), .hit_way_i(hit_way),
    .sing_valid_i(sing_valid), .sing_set_i(sing_set), .sing_way_i(sing_way), .sing_val_i(sing_val),
    .evict_valid_o(evict_valid), .evict_set_o(evict_set), .evict_way_o(evict_way),
    .evict_action_o(evict_action), .spill_valid_o(spill_valid), .spill_ready_i(spill_ready),
    .spill_set_o(spill_set), .spill_target_o(spill_target)
  );

  int checks = 0, errors = 0;
  bit cur_coop, cur_spill;
  bit mv [S][W];
  bit ms [S][W];
  bit mp [S][W];
  int mr [S][W];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic promote(input int s, input int w);
    int r = mr[s][w];
    for (int j = 0; j < W; j++) if (mr[s][j] < r) mr[s][j]++;
    mr[s][w] = 0;
  endtask

  task automatic set_probs(input bit coop, input bit spill);
    @(negedge clk);
    cur_coop = coop; cur_spill = spill;
    coop_prob = coop ? 8'hFF : 8'h00;
    spill_prob = spill ? 8'hFF : 8'h00;
  endtask

  task automatic do_hit(input int s, input int w);
    @(negedge clk);
    hit_valid = 1'b1; hit_set = 2'(s); hit_way = 2'(w);
    @(negedge clk);
    hit_valid = 1'b0;
    if (mv[s][w]) promote(s, w);
    mp[s][w] = 1'b0;
  endtask

  task automatic do_sing(input int s, input int w, input bit v);
    @(negedge clk);
    sing_valid = 1'b1; sing_set = 2'(s); sing_way = 2'(w); sing_val = v;
    @(negedge clk);
    sing_valid = 1'b0;
    ms[s][w] = v;
  endtask

  task automatic do_fill(input int s, input bit sing, input bit spin, input bit both, input string tag);
    int ew = -1, ea, rw = -1;
    string t;
    for (int w = 0; w < W; w++) if (!mv[s][w] && ew < 0) ew = w;
    if (ew >= 0) ea = 0;
    else begin
      if (cur_coop)
        for (int w = 0; w < W; w++)
          if (mv[s][w] && !ms[s][w] && (rw < 0 || mr[s][w] > mr[s][rw])) rw = w;
      if (rw >= 0) ew = rw;
      else for (int w = 0; w < W; w++) if (mr[s][w] == W - 1) ew = w;
      ea = !ms[s][ew] ? 1 : (mp[s][ew] ? 3 : (cur_spill ? 2 : 3));
    end
    if (tag != "") t = tag;
    else if (ea == 0) t = "R2";
    else if (ea == 2) t = "R6";
    else if (ea == 3 && mp[s][ew]) t = "R8";
    else if (ea == 3) t = "R7";
    else if (cur_coop) t = "R3";
    else t = "R4 R5";

    @(negedge clk);
    if (spin && !both) begin
      spin_valid = 1'b1; spin_set = 2'(s);
    end else begin
      fill_valid = 1'b1; fill_set = 2'(s); fill_singlet = sing;
    end
    if (both) begin
      spin_valid = 1'b1; spin_set = 2'((s + 1) % S);
      #1;
      chk("R12", "spin_ready while fill valid", int'(spin_ready), 0);
      chk("R12", "fill_ready", int'(fill_ready), 1);
    end
    @(negedge clk);
    fill_valid = 1'b0; spin_valid = 1'b0;
    chk("R11", "fill_ready after accept", int'(fill_ready), 0);
    chk("R11", "evict_valid early", int'(evict_valid), 0);
    @(negedge clk);
    chk("R11", "evict_valid", int'(evict_valid), 1);
    chk(t, "evict_set", int'(evict_set), s);
    chk(t, "evict_way", int'(evict_way), ew);
    chk(t, "evict_action", int'(evict_action), ea);
    if (ea == 2) begin
      int tg;
      chk("R6", "spill_valid", int'(spill_valid), 1);
      chk("R6", "spill_set", int'(spill_set), s);
      chk("R6", "target is peer", int'(spill_target != 2'(ME)), 1);
      tg = int'(spill_target);
      @(negedge clk);
      chk("R6", "spill held", int'(spill_valid), 1);
      chk("R6", "target stable", int'(spill_target), tg);
      spill_ready = 1'b1;
      @(negedge clk);
      spill_ready = 1'b0;
      chk("R6", "spill released", int'(spill_valid), 0);
    end else begin
      chk(t, "no spill", int'(spill_valid), 0);
    end
    chk("R11", "ready again", int'(fill_ready), 1);
    promote(s, ew);
    mv[s][ew] = 1'b1;
    ms[s][ew] = spin && !both ? 1'b1 : sing;
    mp[s][ew] = spin && !both;
  endtask

  function automatic int mru_way(input int s);
    for (int w = 0; w < W; w++) if (mr[s][w] == 0) return w;
    return 0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    coop_prob = 8'hFF; spill_prob = 8'hFF; cur_coop = 1; cur_spill = 1;
    fill_valid = 0; fill_set = 0; fill_singlet = 0; spin_valid = 0; spin_set = 0;
    hit_valid = 0; hit_set = 0; hit_way = 0; sing_valid = 0; sing_set = 0; sing_way = 0;
    sing_val = 0; spill_ready = 0;
    for (int s = 0; s < S; s++)
      for (int w = 0; w < W; w++) begin
        mv[s][w] = 0; ms[s][w] = 0; mp[s][w] = 0; mr[s][w] = w;
      end
    repeat (3) @(negedge clk);
    chk("R1", "fill_ready", int'(fill_ready), 1);
    chk("R1", "spin_ready", int'(spin_ready), 1);
    chk("R1", "evict_valid", int'(evict_valid), 0);
    chk("R1", "spill_valid", int'(spill_valid), 0);
    rst_n = 1'b1;

    // sweep probability extremes over every set
    for (int cfg = 0; cfg < 4; cfg++) begin
      set_probs(cfg[0], cfg[1]);
      for (int s = 0; s < S; s++)
        for (int k = 0; k < 10; k++) begin
          if (k % 4 == 3) do_hit(s, (k + s + cfg) % W);
          if (k % 5 == 2) do_sing(s, (k * 3 + cfg) % W, bit'((k + s) % 2));
          do_fill(s, ((k + s + cfg) % 3) != 0, k % 3 == 1, 1'b0, "");
        end
    end

    // one chance: spilled-in block aging out unused is dropped
    set_probs(1'b0, 1'b1);
    do_fill(0, 1'b1, 1'b1, 1'b0, "");
    for (int i = 0; i < 3; i++) do_fill(0, 1'b0, 1'b0, 1'b0, "");
    do_fill(0, 1'b1, 1'b0, 1'b0, "R8");

    // reuse clears the spilled mark
    do_fill(1, 1'b1, 1'b1, 1'b0, "");
    do_hit(1, mru_way(1));
    for (int i = 0; i < 3; i++) do_fill(1, 1'b0, 1'b0, 1'b0, "");
    do_fill(1, 1'b1, 1'b0, 1'b0, "R9");

    // singlet update steers the victim to the most recent way
    set_probs(1'b1, 1'b0);
    for (int w = 0; w < W; w++) do_sing(2, w, 1'b1);
    do_sing(2, mru_way(2), 1'b0);
    do_fill(2, 1'b1, 1'b0, 1'b0, "R10");

    // local fill wins over spill-in
    do_fill(3, 1'b0, 1'b0, 1'b1, "R12");

    finish_run();
  end
endmodule